// File: doc/BRIEF.md
# Cluster Power-Down Gatekeeper

This block sits on the power-control channel of a shared cluster domain that holds several cores. The external power controller asks for a new cluster power state by raising a request with a state code. The block answers with an accept or a deny. The cluster can only go to Off once every core domain says it is Off. Each core gives one status bit; the block does not control the cores.

When an Off request is allowed, the block does the clean-up on its own, with no software step. First it asks for the last-level cache to be flushed and waits for the flush to finish. Then it asks the interconnect to stop snooping into the cluster and waits for the acknowledge. Only then does it accept. If a core wakes up while the flush is running, the sequence stops and the request is denied. An On request is accepted at once. A request with an unknown state code is denied.

The controller is one finite state machine with these states:
- `ST_RUN`: cluster On, idle.
- `ST_FLUSH`: cache flush requested.
- `ST_SNOOP`: snoop disable requested.
- `ST_GRANT`: accept held.
- `ST_REFUSE`: deny held.
- `ST_DOWN`: cluster Off, idle.

Its transitions are:
- RUN→FLUSH: Off request, all cores Off.
- RUN→REFUSE: Off request with a core awake, or a bad code.
- RUN→GRANT: On request.
- DOWN→GRANT: Off or On request.
- DOWN→REFUSE: bad code.
- FLUSH→SNOOP: flush done.
- FLUSH→REFUSE: a core left Off.
- SNOOP→GRANT: snoop acknowledge.
- GRANT→DOWN or GRANT→RUN: request dropped, with the target taken from the state just reached.
- REFUSE→DOWN or REFUSE→RUN: request dropped, with the target taken from the state kept.

Top module: `cluster_pwr_gatekeeper`

## Requirements
- R1: After reset the cluster is in the On state and `paccept`, `pdeny`, `flush_req` and `snoop_off_req` are all low.
- R2: `pactive` is high exactly when at least one bit of `core_off` is low (a core not Off), in every state.
- R3: An Off request (`pstate` = 0) made while the cluster is On and any `core_off` bit is low raises `pdeny` one cycle later, and `flush_req` and `snoop_off_req` stay low.
- R4: An Off request made while the cluster is On and all `core_off` bits are high raises `flush_req` one cycle later. `flush_req` then stays high until `flush_done` is sampled high.
- R5: `snoop_off_req` rises only in the cycle after `flush_done` was sampled high while `flush_req` was high. `flush_req` and `snoop_off_req` are never high together.
- R6: `paccept` for a power-down rises in the cycle after `snoop_ack` is sampled high, and `snoop_off_req` falls at the same time.
- R7: If any `core_off` bit goes low while `flush_req` is high, `flush_req` falls and `pdeny` rises one cycle later. The cluster stays On.
- R8: `paccept` or `pdeny`, once high, stays high while `preq` is high and falls one cycle after `preq` is sampled low. The two are never high together.
- R9: An On request (`pstate` = 1) is accepted one cycle later, from either cluster state, with no flush or snoop activity. After it, the cluster is On.
- R10: A request whose `pstate` code is neither 0 nor 1 is denied one cycle later and leaves the cluster state unchanged.
- R11: An Off request while the cluster is already Off is accepted one cycle later with no flush or snoop activity, whatever `core_off` shows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_off | input | NUM_CORES | Per-core status, 1 = that core domain is Off |
| preq | input | 1 | Power-state change request from the controller |
| pstate | input | PSTATE_W | Requested state code: 0 = Off, 1 = On |
| paccept | output | 1 | Request accepted |
| pdeny | output | 1 | Request denied |
| pactive | output | 1 | Cluster needs to stay On |
| flush_req | output | 1 | Last-level cache flush request |
| flush_done | input | 1 | Flush completed |
| snoop_off_req | output | 1 | Ask the interconnect to stop snooping into the cluster |
| snoop_ack | input | 1 | Interconnect confirms snooping is stopped |

## Verification
A wrong state register first shows up on the handshake outputs. It shows up one cycle after the edge where the wrong transition was taken. One example is a flush request with a core awake. Another is a snoop request that starts before the flush finishes. A third is an accept that comes without the acknowledge. A wrong cluster Off/On record stays hidden until the next request. The bench therefore always follows a power-down with another request. That request shows whether the block still counts the cluster as Off, which decides whether it replies at once or starts a new flush. A wrong sum of the core statuses shows on `pactive` in the same cycle as the change.

// File: rtl/gk_pkg.sv
package gk_pkg;

    // Controller states of the gatekeeper sequencer
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_FLUSH  = 3'd1,
        ST_SNOOP  = 3'd2,
        ST_GRANT  = 3'd3,
        ST_REFUSE = 3'd4,
        ST_DOWN   = 3'd5
    } gk_state_e;

    // Decoded request class
    typedef struct packed {
        logic want_off;
        logic want_on;
        logic bad_code;
    } gk_req_t;

endpackage

// File: rtl/gk_core_vote.sv
module gk_core_vote #(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0] core_off,
    output logic                 all_off,
    output logic                 any_awake
);

    localparam int LAST = NUM_CORES - 1;

    // Chain of partial AND terms, one per core
    logic [NUM_CORES-1:0] chain;

    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_chain
            if (g == 0) begin : g_first
                assign chain[g] = core_off[g];
            end else begin : g_next
                assign chain[g] = chain[g-1] & core_off[g];
            end
        end
    endgenerate

    assign all_off   = chain[LAST];
    assign any_awake = ~chain[LAST];

endmodule

// File: rtl/gk_req_decode.sv
module gk_req_decode
    import gk_pkg::*;
#(
    parameter int                      PSTATE_W = 2,
    parameter logic [PSTATE_W-1:0]     CODE_OFF = '0,
    parameter logic [PSTATE_W-1:0]     CODE_ON  = PSTATE_W'(1)
) (
    input  logic                preq,
    input  logic [PSTATE_W-1:0] pstate,
    output gk_req_t             req
);

    always_comb begin
        req          = '0;
        req.want_off = preq && (pstate == CODE_OFF);
        req.want_on  = preq && (pstate == CODE_ON);
        req.bad_code = preq && (pstate != CODE_OFF) && (pstate != CODE_ON);
    end

endmodule

// File: rtl/gk_seq_fsm.sv
module gk_seq_fsm
    import gk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      preq,
    input  gk_req_t   req,
    input  logic      all_off,
    input  logic      flush_done,
    input  logic      snoop_ack,
    output gk_state_e state
);

    gk_state_e state_d;
    logic      off_q;
    logic      off_d;

    // State register, including the recorded cluster power state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            off_q <= 1'b0;
        end else begin
            state <= state_d;
            off_q <= off_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        off_d   = off_q;
        unique case (state)
            ST_RUN: begin
                if (req.bad_code) begin
                    state_d = ST_REFUSE;
                end else if (req.want_on) begin
                    state_d = ST_GRANT;
                end else if (req.want_off) begin
                    state_d = all_off ? ST_FLUSH : ST_REFUSE;
                end
            end
            ST_DOWN: begin
                if (req.bad_code) begin
                    state_d = ST_REFUSE;
                end else if (req.want_on || req.want_off) begin
                    state_d = ST_GRANT;
                    off_d   = req.want_off;
                end
            end
            ST_FLUSH: begin
                if (!all_off) begin
                    state_d = ST_REFUSE;
                end else if (flush_done) begin
                    state_d = ST_SNOOP;
                end
            end
            ST_SNOOP: begin
                if (snoop_ack) begin
                    state_d = ST_GRANT;
                    off_d   = 1'b1;
                end
            end
            ST_GRANT, ST_REFUSE: begin
                if (!preq) begin
                    state_d = off_q ? ST_DOWN : ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
                off_d   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gk_out_decode.sv
module gk_out_decode
    import gk_pkg::*;
(
    input  gk_state_e state,
    output logic      paccept,
    output logic      pdeny,
    output logic      flush_req,
    output logic      snoop_off_req
);

    // Moore outputs, one per handshake
    always_comb begin
        paccept       = 1'b0;
        pdeny         = 1'b0;
        flush_req     = 1'b0;
        snoop_off_req = 1'b0;
        unique case (state)
            ST_FLUSH:  flush_req     = 1'b1;
            ST_SNOOP:  snoop_off_req = 1'b1;
            ST_GRANT:  paccept       = 1'b1;
            ST_REFUSE: pdeny         = 1'b1;
            ST_RUN, ST_DOWN: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/cluster_pwr_gatekeeper.sv
module cluster_pwr_gatekeeper
    import gk_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int PSTATE_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] core_off,
    input  logic                 preq,
    input  logic [PSTATE_W-1:0]  pstate,
    output logic                 paccept,
    output logic                 pdeny,
    output logic                 pactive,
    output logic                 flush_req,
    input  logic                 flush_done,
    output logic                 snoop_off_req,
    input  logic                 snoop_ack
);

    localparam logic [PSTATE_W-1:0] CODE_OFF = '0;
    localparam logic [PSTATE_W-1:0] CODE_ON  = PSTATE_W'(1);

    logic      all_off;
    logic      any_awake;
    gk_req_t   req;
    gk_state_e state;

    gk_core_vote #(.NUM_CORES(NUM_CORES)) u_vote (
        .core_off  (core_off),
        .all_off   (all_off),
        .any_awake (any_awake)
    );

    gk_req_decode #(
        .PSTATE_W (PSTATE_W),
        .CODE_OFF (CODE_OFF),
        .CODE_ON  (CODE_ON)
    ) u_dec (
        .preq   (preq),
        .pstate (pstate),
        .req    (req)
    );

    gk_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .preq       (preq),
        .req        (req),
        .all_off    (all_off),
        .flush_done (flush_done),
        .snoop_ack  (snoop_ack),
        .state      (state)
    );

    gk_out_decode u_out (
        .state         (state),
        .paccept       (paccept),
        .pdeny         (pdeny),
        .flush_req     (flush_req),
        .snoop_off_req (snoop_off_req)
    );

    assign pactive = any_awake;

endmodule

// File: rtl/gk_checker.sv
module gk_checker #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] core_off,
    input logic                 preq,
    input logic                 paccept,
    input logic                 pdeny,
    input logic                 flush_req,
    input logic                 flush_done,
    input logic                 snoop_off_req,
    input logic                 snoop_ack
);

    AST_FLUSH_NEEDS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(&core_off)); // R4

    AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_done && (&core_off) |=> flush_req); // R4

    AST_DENY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pdeny |-> !flush_req && !snoop_off_req); // R3

    AST_SNOOP_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snoop_off_req) |-> $past(flush_req && flush_done)); // R5

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req && snoop_off_req)); // R5

    AST_ACCEPT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snoop_off_req) |-> paccept && $past(snoop_ack)); // R6

    AST_ABORT_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !(&core_off) |=> pdeny && !flush_req); // R7

    AST_ANSWER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(paccept && pdeny)); // R8

    AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        paccept && preq |=> paccept); // R8

    AST_DENY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pdeny && preq |=> pdeny); // R8

    AST_ANSWER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (paccept || pdeny) && !preq |=> !paccept && !pdeny); // R8

endmodule

bind cluster_pwr_gatekeeper gk_checker #(.NUM_CORES(NUM_CORES)) u_gk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_off      (core_off),
    .preq          (preq),
    .paccept       (paccept),
    .pdeny         (pdeny),
    .flush_req     (flush_req),
    .flush_done    (flush_done),
    .snoop_off_req (snoop_off_req),
    .snoop_ack     (snoop_ack)
);

// File: tb/test_cluster_pwr_gatekeeper.sv
module test_cluster_pwr_gatekeeper;

    localparam int CLK_PERIOD = 10;
    localparam int NC         = 4;
    localparam int PW         = 2;
    localparam int WATCHDOG   = 100000;

    // Outcome classes of a request
    localparam int OUT_DENY  = 0;
    localparam int OUT_GRANT = 1;
    localparam int OUT_SEQ   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] core_off = '1;
    logic          preq = 1'b0;
    logic [PW-1:0] pstate = '0;
    logic          flush_done = 1'b0;
    logic          snoop_ack = 1'b0;
    logic          paccept, pdeny, pactive, flush_req, snoop_off_req;

    int  checks = 0;
    int  failures = 0;
    bit  model_off = 1'b0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cluster_pwr_gatekeeper #(.NUM_CORES(NC), .PSTATE_W(PW)) i_cluster_pwr_gatekeeper (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_off      (core_off),
        .preq          (preq),
        .pstate        (pstate),
        .paccept       (paccept),
        .pdeny         (pdeny),
        .pactive       (pactive),
        .flush_req     (flush_req),
        .flush_done    (flush_done),
        .snoop_off_req (snoop_off_req),
        .snoop_ack     (snoop_ack)
    );

    // Expected outcome from the requirements (R3, R9, R10, R11)
    function automatic int exp_outcome(input logic [PW-1:0] pst, input logic [NC-1:0] cores,
                                       input bit is_off);
        if (pst > 1)         return OUT_DENY;
        if (pst == 1)        return OUT_GRANT;
        if (is_off)          return OUT_GRANT;
        if (cores == '1)     return OUT_SEQ;
        return OUT_DENY;
    endfunction

    function automatic logic exp_pactive(input logic [NC-1:0] cores);
        return (cores != '1);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_outs(input logic a, input logic d, input logic f, input logic s,
                            input string tag);
        chk(paccept, a, {tag, " paccept"});
        chk(pdeny, d, {tag, " pdeny"});
        chk(flush_req, f, {tag, " flush_req"});
        chk(snoop_off_req, s, {tag, " snoop_off_req"});
        chk(pactive, exp_pactive(core_off), "R2 pactive");
    endtask

    // One full request: drive at negedge, check at following negedges
    task automatic do_req(input logic [PW-1:0] pst, input logic [NC-1:0] cores,
                          input int flat, input int slat, input bit abort_it, input int hold);
        int oc;
        bit granted;
        oc = exp_outcome(pst, cores, model_off);
        granted = 1'b0;
        @(negedge clk);
        core_off = cores;
        pstate   = pst;
        preq     = 1'b1;
        @(negedge clk);
        if (oc == OUT_DENY) begin
            chk_outs(1'b0, 1'b1, 1'b0, 1'b0, (pst > 1) ? "R10" : "R3");
        end else if (oc == OUT_GRANT) begin
            chk_outs(1'b1, 1'b0, 1'b0, 1'b0, (pst == 1) ? "R9" : "R11");
            granted = 1'b1;
        end else begin
            chk_outs(1'b0, 1'b0, 1'b1, 1'b0, "R4 flush start");
            for (int i = 0; i < flat; i++) begin
                @(negedge clk);
                chk_outs(1'b0, 1'b0, 1'b1, 1'b0, "R4 flush wait");
            end
            if (abort_it) begin
                core_off[$urandom_range(NC-1, 0)] = 1'b0;
                @(negedge clk);
                chk_outs(1'b0, 1'b1, 1'b0, 1'b0, "R7 abort");
            end else begin
                flush_done = 1'b1;
                @(negedge clk);
                flush_done = 1'b0;
                chk_outs(1'b0, 1'b0, 1'b0, 1'b1, "R5 snoop start");
                for (int i = 0; i < slat; i++) begin
                    @(negedge clk);
                    chk_outs(1'b0, 1'b0, 1'b0, 1'b1, "R6 snoop wait");
                end
                snoop_ack = 1'b1;
                @(negedge clk);
                snoop_ack = 1'b0;
                chk_outs(1'b1, 1'b0, 1'b0, 1'b0, "R6 accept");
                granted = 1'b1;
            end
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(paccept, granted, "R8 hold paccept");
            chk(pdeny, !granted, "R8 hold pdeny");
        end
        preq = 1'b0;
        @(negedge clk);
        chk_outs(1'b0, 1'b0, 1'b0, 1'b0, "R8 release");
        if (granted) model_off = (pst == 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_outs(1'b0, 1'b0, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs(1'b0, 1'b0, 1'b0, 1'b0, "R1 after reset");

        // Directed corner cases
        do_req(2'd0, 4'b1011, 0, 0, 1'b0, 1);   // R3 one core awake
        do_req(2'd2, 4'b1111, 0, 0, 1'b0, 1);   // R10 bad code while On
        do_req(2'd1, 4'b0000, 0, 0, 1'b0, 0);   // R9 On while On
        do_req(2'd0, 4'b1111, 3, 2, 1'b1, 1);   // R7 abort mid flush
        do_req(2'd0, 4'b1111, 0, 0, 1'b0, 2);   // R4/R5/R6 zero latency
        do_req(2'd0, 4'b0101, 0, 0, 1'b0, 1);   // R11 Off while Off
        do_req(2'd3, 4'b1111, 0, 0, 1'b0, 0);   // R10 bad code while Off
        do_req(2'd1, 4'b0110, 0, 0, 1'b0, 1);   // R9 On from Off
        do_req(2'd0, 4'b1111, 5, 4, 1'b0, 0);   // R4/R6 long latency

        // Constrained random traffic
        for (int n = 0; n < 150; n++) begin
            logic [PW-1:0] p;
            logic [NC-1:0] c;
            int r;
            r = $urandom_range(9, 0);
            p = (r < 6) ? 2'd0 : (r < 9) ? 2'd1 : 2'($urandom_range(3, 2));
            c = ($urandom_range(1, 0) == 1) ? '1 : NC'($urandom);
            do_req(p, c, $urandom_range(4, 0), $urandom_range(4, 0),
                   ($urandom_range(3, 0) == 0), $urandom_range(2, 0));
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                core_off = NC'($urandom);
                #1;
                chk(pactive, exp_pactive(core_off), "R2 idle pactive");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule